// File: doc/BRIEF.md
# Banked UART Register Access Controller

This block is the host-side register file of a single UART channel. A host drives a 3-bit address, a write strobe and a read strobe. Read data comes back combinationally in the same cycle as the read strobe. Three register sets share the eight addresses. A write-only bank selector at a fixed address decides which set is visible. The same selector can also expose two read-only FIFO level counters in place of the scratchpad.

The bank selector is held as a small state machine with five states:

- `ST_GENERAL`: the general set, with the counters hidden.
- `ST_GEN_LVL`: the general set, with the counters visible.
- `ST_EXTRA1`: the first extra set, which holds the divisor bytes.
- `ST_EXTRA2`: the second extra set, which has no registers mapped in this block.
- `ST_RESERVED`: the reserved selector code.

Every transition happens on a write to the selector address, and the written byte picks the next state:

- Selector bits [2:1] = 00 with bit 0 = 0 leads to `ST_GENERAL`.
- Selector bits [2:1] = 00 with bit 0 = 1 leads to `ST_GEN_LVL`.
- Selector bits [2:1] = 01 leads to `ST_EXTRA1`.
- Selector bits [2:1] = 10 leads to `ST_EXTRA2`.
- Selector bits [2:1] = 11 leads to `ST_RESERVED`.

Any state can reach any other state this way. Reset forces `ST_GENERAL`.

The block also holds the 8-bit scratchpad and the 16-bit baud divisor. The divisor drives the baud generator through the `divisor` output. The transmit free-space count and the receive fill count arrive from the FIFOs on input ports. They are clamped to the FIFO depth before they are returned.

Top module: `uart_bank_regs`

## Requirements
- R1: Synchronous active-high `rst` returns the bank state to `ST_GENERAL` and clears the scratchpad and the divisor to zero.
- R2: A write to address 3 loads the selector from `wdata`. Bits [2:1] pick the state: 00 gives `ST_GENERAL` if bit 0 is 0 and `ST_GEN_LVL` if bit 0 is 1, 01 gives `ST_EXTRA1`, 10 gives `ST_EXTRA2` and 11 gives `ST_RESERVED`. Bits [7:3] have no effect.
- R3: A read of address 3 returns 0x00 in every bank. The address-3 write path works from every bank.
- R4: In `ST_GENERAL`, address 7 is the scratchpad: a write stores the byte and a read returns it.
- R5: In `ST_GEN_LVL`, a read of address 7 returns the receive fill count and a read of address 6 returns the transmit free count. A write to address 7 is ignored, so the scratchpad keeps its value.
- R6: When selector bits [2:1] are nonzero, bit 0 has no effect: reads of addresses 6 and 7 return 0x00.
- R7: In `ST_EXTRA1`, address 0 is the divisor low byte and address 1 is the divisor high byte. Both can be written and read back, and the `divisor` output follows them from the next cycle.
- R8: In `ST_EXTRA2` and `ST_RESERVED`, every read returns 0x00 and every write other than to address 3 is ignored.
- R9: `rdata` is 0x00 whenever `rd_en` is low.
- R10: A level count above the FIFO depth (128) is returned as 128.
- R11: Writes to addresses 0 and 1 outside `ST_EXTRA1` leave the divisor unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| rd_en | input | 1 | Read strobe, qualifies `rdata` |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| tx_free | input | 8 | Free entries in the transmit FIFO |
| rx_fill | input | 8 | Characters held in the receive FIFO |
| divisor | output | 16 | Baud divisor to the generator |

## Verification
The selector is driven with each of the four bank codes, with bit 0 both clear and set, and with the reserved upper bits set. This separates bank priority from the level-enable bit and shows that bits [7:3] are ignored. Addresses 6 and 7 are read in each state with distinct scratchpad, transmit and receive values. This shows which source the multiplexer picked. Divisor and scratchpad writes are issued from the wrong banks and then read back from the right bank, which exposes any write that leaked through. Counts of 255 and 200 test the clamp, against in-range counts of 100 and 37.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;

    localparam int ADDR_W = 3;

    // Shared address map; the selector lives at one fixed address in every bank.
    localparam logic [ADDR_W-1:0] SEL_ADDR   = 3'd3;
    localparam logic [ADDR_W-1:0] SCR_ADDR   = 3'd7;
    localparam logic [ADDR_W-1:0] RXLVL_ADDR = 3'd7;
    localparam logic [ADDR_W-1:0] TXLVL_ADDR = 3'd6;
    localparam logic [ADDR_W-1:0] DIVLO_ADDR = 3'd0;
    localparam logic [ADDR_W-1:0] DIVHI_ADDR = 3'd1;

    typedef enum logic [2:0] {
        ST_GENERAL  = 3'd0,
        ST_GEN_LVL  = 3'd1,
        ST_EXTRA1   = 3'd2,
        ST_EXTRA2   = 3'd3,
        ST_RESERVED = 3'd4
    } bank_state_t;

endpackage

// File: rtl/bank_sel_fsm.sv
module bank_sel_fsm
    import uart_bank_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output bank_state_t       state,
    output logic              scr_wr_ok,
    output logic              div_wr_ok,
    output logic              lvl_visible
);

    bank_state_t nxt_state;
    logic        sel_write;

    assign sel_write = wr_en && (addr == SEL_ADDR);

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_GENERAL;
        end else begin
            state <= nxt_state;
        end
    end

    // Next state: bank code wins over the level-enable bit.
    always_comb begin
        nxt_state = state;
        if (sel_write) begin
            unique case (wdata[2:1])
                2'b00:   nxt_state = wdata[0] ? ST_GEN_LVL : ST_GENERAL;
                2'b01:   nxt_state = ST_EXTRA1;
                2'b10:   nxt_state = ST_EXTRA2;
                default: nxt_state = ST_RESERVED;
            endcase
        end
    end

    // Decoded per-state enables.
    always_comb begin
        scr_wr_ok   = 1'b0;
        div_wr_ok   = 1'b0;
        lvl_visible = 1'b0;
        unique case (state)
            ST_GENERAL:  scr_wr_ok   = 1'b1;
            ST_GEN_LVL:  lvl_visible = 1'b1;
            ST_EXTRA1:   div_wr_ok   = 1'b1;
            ST_EXTRA2:   ;
            ST_RESERVED: ;
            default:     ;
        endcase
    end

endmodule

// File: rtl/bank_reg_store.sv
module bank_reg_store
    import uart_bank_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              scr_wr_ok,
    input  logic              div_wr_ok,
    output logic [DATA_W-1:0] scratch,
    output logic [DIV_W-1:0]  divisor
);

    logic scr_we;
    logic lo_we;
    logic hi_we;

    assign scr_we = wr_en && scr_wr_ok && (addr == SCR_ADDR);
    assign lo_we  = wr_en && div_wr_ok && (addr == DIVLO_ADDR);
    assign hi_we  = wr_en && div_wr_ok && (addr == DIVHI_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            scratch <= '0;
        end else if (scr_we) begin
            scratch <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            divisor <= '0;
        end else begin
            if (lo_we) divisor[DATA_W-1:0]     <= wdata;
            if (hi_we) divisor[DIV_W-1:DATA_W] <= wdata;
        end
    end

endmodule

// File: rtl/bank_read_mux.sv
module bank_read_mux
    import uart_bank_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int DIV_W      = 2 * DATA_W,
    parameter int FIFO_DEPTH = 128,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  bank_state_t       state,
    input  logic [DATA_W-1:0] scratch,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [CNT_W-1:0]  tx_free,
    input  logic [CNT_W-1:0]  rx_fill,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(FIFO_DEPTH);

    logic [CNT_W-1:0] tx_clamp;
    logic [CNT_W-1:0] rx_clamp;

    assign tx_clamp = (tx_free > DEPTH_C) ? DEPTH_C : tx_free;
    assign rx_clamp = (rx_fill > DEPTH_C) ? DEPTH_C : rx_fill;

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (state)
                ST_GENERAL: begin
                    if (addr == SCR_ADDR) rdata = scratch;
                end
                ST_GEN_LVL: begin
                    if (addr == RXLVL_ADDR)      rdata = DATA_W'(rx_clamp);
                    else if (addr == TXLVL_ADDR) rdata = DATA_W'(tx_clamp);
                end
                ST_EXTRA1: begin
                    if (addr == DIVLO_ADDR)      rdata = divisor[DATA_W-1:0];
                    else if (addr == DIVHI_ADDR) rdata = divisor[DIV_W-1:DATA_W];
                end
                ST_EXTRA2:   rdata = '0;
                ST_RESERVED: rdata = '0;
                default:     rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
    import uart_bank_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 128,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
    parameter int DIV_W      = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [CNT_W-1:0]  tx_free,
    input  logic [CNT_W-1:0]  rx_fill,
    output logic [DIV_W-1:0]  divisor
);

    bank_state_t       state;
    logic              scr_wr_ok;
    logic              div_wr_ok;
    logic              lvl_visible;
    logic [DATA_W-1:0] scratch;

    bank_sel_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .state       (state),
        .scr_wr_ok   (scr_wr_ok),
        .div_wr_ok   (div_wr_ok),
        .lvl_visible (lvl_visible)
    );

    bank_reg_store #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .scr_wr_ok (scr_wr_ok),
        .div_wr_ok (div_wr_ok),
        .scratch   (scratch),
        .divisor   (divisor)
    );

    bank_read_mux #(
        .DATA_W(DATA_W), .DIV_W(DIV_W), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
    ) u_rmux (
        .rd_en   (rd_en),
        .addr    (addr),
        .state   (state),
        .scratch (scratch),
        .divisor (divisor),
        .tx_free (tx_free),
        .rx_fill (rx_fill),
        .rdata   (rdata)
    );

endmodule

// File: rtl/uart_bank_regs_chk.sv
module uart_bank_regs_chk
    import uart_bank_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 128,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
    parameter int DIV_W      = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [CNT_W-1:0]  rx_fill,
    input logic [DIV_W-1:0]  divisor,
    input logic [DATA_W-1:0] scratch,
    input bank_state_t       state
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(FIFO_DEPTH);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state == ST_GENERAL) && (divisor == '0) && (scratch == '0));

    p_sel_extra1_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == SEL_ADDR && wdata[2:1] == 2'b01) |=> (state == ST_EXTRA1));

    p_sel_read_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == SEL_ADDR) |-> (rdata == '0));

    p_scratch_store_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && state == ST_GENERAL && addr == SCR_ADDR) |=> (scratch == $past(wdata)));

    p_rx_level_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && state == ST_GEN_LVL && addr == RXLVL_ADDR)
            |-> (rdata == DATA_W'((rx_fill > DEPTH_C) ? DEPTH_C : rx_fill)));

    p_bank_priority_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && state != ST_GENERAL && state != ST_GEN_LVL && addr >= 3'd6) |-> (rdata == '0));

    p_empty_banks_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (state == ST_EXTRA2 || state == ST_RESERVED)) |-> (rdata == '0));

    p_idle_read_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rdata == '0));

    p_level_bound_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && state == ST_GEN_LVL) |-> (rdata <= DATA_W'(DEPTH_C)));

    p_divisor_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && state == ST_EXTRA1 && (addr == DIVLO_ADDR || addr == DIVHI_ADDR))
            |=> $stable(divisor));

endmodule

bind uart_bank_regs uart_bank_regs_chk #(
    .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .DIV_W(DIV_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wdata   (wdata),
    .rdata   (rdata),
    .rx_fill (rx_fill),
    .divisor (divisor),
    .scratch (scratch),
    .state   (state)
);

// File: tb/uart_bank_regs_tb.sv
module uart_bank_regs_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [7:0]  tx_free = 8'd100;
    logic [7:0]  rx_fill = 8'd37;
    logic [15:0] divisor;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    uart_bank_regs u_dut (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wdata   (wdata),
        .rdata   (rdata),
        .tx_free (tx_free),
        .rx_fill (rx_fill),
        .divisor (divisor)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        wr(3'd3, 8'h00); wr(3'd7, 8'hA5);
        wr(3'd3, 8'h02); wr(3'd0, 8'h34); wr(3'd1, 8'h12);
        do_reset();
        check("R1 divisor after reset", divisor, 16'h0000);
        rd(3'd7, d); check("R1 scratch after reset", {8'h0, d}, 16'h0000);
        rd(3'd6, d); check("R1 counters hidden after reset", {8'h0, d}, 16'h0000);
    endtask

    task automatic t_scratch();
        logic [7:0] d;
        wr(3'd7, 8'h5A);
        rd(3'd7, d); check("R4 scratch readback", {8'h0, d}, 16'h005A);
        wr(3'd7, 8'hC3);
        rd(3'd7, d); check("R4 scratch overwrite", {8'h0, d}, 16'h00C3);
    endtask

    task automatic t_levels();
        logic [7:0] d;
        wr(3'd3, 8'h01);
        rd(3'd7, d); check("R5 rx level", {8'h0, d}, 16'd37);
        rd(3'd6, d); check("R5 tx level", {8'h0, d}, 16'd100);
        wr(3'd7, 8'h11);
        wr(3'd3, 8'h00);
        rd(3'd7, d); check("R5 scratch untouched by level-mode write", {8'h0, d}, 16'h00C3);
    endtask

    task automatic t_reserved_bits();
        logic [7:0] d;
        wr(3'd3, 8'hF8);
        rd(3'd7, d); check("R2 upper bits ignored (general)", {8'h0, d}, 16'h00C3);
        wr(3'd3, 8'hF9);
        rd(3'd7, d); check("R2 upper bits ignored (levels)", {8'h0, d}, 16'd37);
    endtask

    task automatic t_sel_read();
        logic [7:0] d;
        wr(3'd3, 8'h00); rd(3'd3, d); check("R3 selector read general", {8'h0, d}, 16'h0);
        wr(3'd3, 8'h01); rd(3'd3, d); check("R3 selector read levels", {8'h0, d}, 16'h0);
        wr(3'd3, 8'h02); rd(3'd3, d); check("R3 selector read extra1", {8'h0, d}, 16'h0);
        wr(3'd3, 8'h06); rd(3'd3, d); check("R3 selector read reserved", {8'h0, d}, 16'h0);
        wr(3'd3, 8'h00); rd(3'd7, d); check("R3 return to general", {8'h0, d}, 16'h00C3);
    endtask

    task automatic t_divisor();
        logic [7:0] d;
        wr(3'd3, 8'h02);
        wr(3'd0, 8'h9C); wr(3'd1, 8'h04);
        check("R7 divisor output", divisor, 16'h049C);
        rd(3'd0, d); check("R7 divisor low read", {8'h0, d}, 16'h009C);
        rd(3'd1, d); check("R7 divisor high read", {8'h0, d}, 16'h0004);
    endtask

    task automatic t_priority();
        logic [7:0] d;
        wr(3'd3, 8'h03);
        rd(3'd7, d); check("R6 extra1+bit0 addr7", {8'h0, d}, 16'h0);
        rd(3'd6, d); check("R6 extra1+bit0 addr6", {8'h0, d}, 16'h0);
        rd(3'd0, d); check("R6 extra1 still visible", {8'h0, d}, 16'h009C);
        wr(3'd3, 8'h05);
        rd(3'd7, d); check("R6 extra2+bit0 addr7", {8'h0, d}, 16'h0);
    endtask

    task automatic t_empty_banks();
        logic [7:0] d;
        int bad;
        wr(3'd3, 8'h04);
        wr(3'd0, 8'hFF); wr(3'd1, 8'hEE); wr(3'd7, 8'h77);
        bad = 0;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            if (d != 8'h00) bad++;
        end
        check("R8 extra2 reads all zero", 16'(bad), 16'h0);
        check("R8 extra2 writes ignored", divisor, 16'h049C);
        wr(3'd3, 8'h06);
        wr(3'd0, 8'h11); wr(3'd1, 8'h22);
        rd(3'd0, d); check("R8 reserved read zero", {8'h0, d}, 16'h0);
        check("R8 reserved writes ignored", divisor, 16'h049C);
        wr(3'd3, 8'h00);
        rd(3'd7, d); check("R8 scratch unchanged", {8'h0, d}, 16'h00C3);
    endtask

    task automatic t_general_div();
        wr(3'd3, 8'h00); wr(3'd0, 8'h55); wr(3'd1, 8'h66);
        check("R11 general writes skip divisor", divisor, 16'h049C);
        wr(3'd3, 8'h01); wr(3'd0, 8'h55);
        check("R11 level-mode writes skip divisor", divisor, 16'h049C);
    endtask

    task automatic t_idle();
        @(negedge clk);
        addr = 3'd7; rd_en = 1'b0;
        #1;
        check("R9 rdata idle", {8'h0, rdata}, 16'h0);
    endtask

    task automatic t_clamp();
        logic [7:0] d;
        wr(3'd3, 8'h01);
        tx_free = 8'd255; rx_fill = 8'd200;
        rd(3'd7, d); check("R10 rx clamp", {8'h0, d}, 16'd128);
        rd(3'd6, d); check("R10 tx clamp", {8'h0, d}, 16'd128);
        tx_free = 8'd128;
        rd(3'd6, d); check("R10 tx at depth", {8'h0, d}, 16'd128);
        tx_free = 8'd100; rx_fill = 8'd37;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_scratch();
        t_levels();
        t_reserved_bits();
        t_sel_read();
        t_divisor();
        t_priority();
        t_empty_banks();
        t_general_div();
        t_idle();
        t_clamp();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule